// File: doc/BRIEF.md
# SMBus Block-Access Control Register Slave

This block is a bus-slave front end for a small clock-distribution control register file. It listens on a two-wire SMBus (clock and open-drain data), answers one fixed 7-bit device address, and serves indexed block transfers. A write carries a starting register index, a byte count and that many data bytes, stored into consecutive registers. A read follows a write of the index with a repeated START and the read address. The slave then returns a byte count followed by register contents until the host NACKs. The index advances after every data byte and wraps at the end of the register file.

The register contents drive parallel control outputs: a PLL/bypass select, a loop-bandwidth select, a power-down mode bit and four per-output enables. A read-only identifier register sits in the map. While the external power-down input is high, the slave refuses all access. The slave has no clock stretching and no packet error code. SCL and SDA are oversampled by the system clock through two-flop synchronisers.

Top module: `smbus_ctl_regs`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits are 1101110 (bit 0 is R/W, 0 = write, 1 = read). Any other address is NACKed, and the rest of that transfer is ignored.
- R2: The slave changes its SDA drive only while SCL is low. It pulls SDA low in the ACK slot of every byte it accepts.
- R3: A write transfer is address(W), index byte, count byte N, then N data bytes. Data byte k goes to register (index + k) mod 8 and is ACKed. Data bytes beyond N are NACKed and discarded.
- R4: A count byte of 0 in a write is NACKed, and no register changes.
- R5: A read is a write of address(W) and index, a repeated START, then address(R). The slave sends a count byte equal to the register count (8), then register contents from the index upward, until the host answers a byte with NACK.
- R6: Register 0 bit 1 drives `pll_sel` (reset 1), bit 2 drives `bw_low` (reset 1) and bit 7 drives `pd_mode` (reset 0). Register 1 bits 1, 2, 5 and 6 drive `out_en[0..3]` (reset 1). Register 4 reads 0x20.
- R7: Writes to reserved bits, reserved registers and register 4 are ACKed but discarded. Reserved bits and registers read back 0.
- R8: While `pwr_down` is high, the slave NACKs address bytes and any byte it receives, and no control output changes. This includes power-down rising in the middle of a write.
- R9: A STOP after any whole byte ends the transfer and releases SDA. Bytes already written stay written, and the next START begins a fresh transfer.
- R10: The register index wraps from 7 to 0 during both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | High: power-down active, register access locked |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | High: pull the open-drain data line low |
| pll_sel | output | 1 | 1 = PLL path, 0 = bypass/fan-out |
| bw_low | output | 1 | 1 = low PLL bandwidth, 0 = high |
| pd_mode | output | 1 | Power-down mode select bit |
| out_en | output | 4 | Per-output clock enables |

## Verification
Two functions can act in the same cycle: the lockout from `pwr_down` and the accept-and-store decision taken on the SCL fall after the eighth bit of a data byte. The bench opens a valid write and lets the address, index and count be ACKed. It then raises `pwr_down` while the data byte is being shifted in, so that the lock is active when the store decision is made. The bench judges the result by the NACK it samples in the ACK slot and by the register 0 outputs, which must keep their prior values. A later readback, after the lock is released, confirms that nothing was stored.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RXACK,
        PH_TX,
        PH_TXACK,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_INDEX,
        K_COUNT,
        K_DATA
    } kind_e;

    // Fixed positions decoded by the clock-control neighbours.
    localparam int CTRL_REG   = 0;
    localparam int ENA_REG    = 1;
    localparam int ID_REG     = 4;
    localparam logic [7:0] ID_VALUE = 8'h20;

    localparam int PLL_BIT = 1;
    localparam int BW_BIT  = 2;
    localparam int PD_BIT  = 7;

    // Bit of the enable register that drives output n.
    function automatic int ena_bit(input int n);
        return (n < 2) ? n + 1 : n + 3;
    endfunction

    // Writable bits per register.
    function automatic logic [7:0] wr_mask(input int r);
        case (r)
            CTRL_REG: wr_mask = 8'h86;
            ENA_REG:  wr_mask = 8'h66;
            default:  wr_mask = 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rst_value(input int r);
        case (r)
            CTRL_REG: rst_value = 8'h06;
            ENA_REG:  rst_value = 8'h66;
            default:  rst_value = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbr_linesync.sv
module smbr_linesync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    typedef struct packed {
        logic scl_m;
        logic sda_m;
        logic scl_s;
        logic sda_s;
        logic scl_p;
        logic sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl_m = scl_i;
        s_d.sda_m = sda_i;
        s_d.scl_s = s_q.scl_m;
        s_d.sda_s = s_q.sda_m;
        s_d.scl_p = s_q.scl_s;
        s_d.sda_p = s_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o      = s_q.scl_s;
    assign sda_o      = s_q.sda_s;
    assign start_o    = s_q.scl_s & s_q.scl_p & s_q.sda_p & ~s_q.sda_s;
    assign stop_o     = s_q.scl_s & s_q.scl_p & ~s_q.sda_p & s_q.sda_s;
    assign scl_rise_o = s_q.scl_s & ~s_q.scl_p;
    assign scl_fall_o = ~s_q.scl_s & s_q.scl_p;

endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile
    import smbr_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [7:0]      rd_data,
    output logic [7:0]      ctrl_o,
    output logic [7:0]      ena_o
);

    logic [7:0] regs_d [NREGS];
    logic [7:0] regs_q [NREGS];

    always_comb begin
        for (int r = 0; r < NREGS; r++) begin
            regs_d[r] = regs_q[r];
            if (wr_en && (int'(wr_idx) == r))
                regs_d[r] = wr_data & wr_mask(r);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) regs_q[r] <= rst_value(r);
        end else begin
            for (int r = 0; r < NREGS; r++) regs_q[r] <= regs_d[r];
        end
    end

    assign rd_data = (int'(rd_idx) == ID_REG) ? ID_VALUE : regs_q[rd_idx];
    assign ctrl_o  = regs_q[CTRL_REG];
    assign ena_o   = regs_q[ENA_REG];

    // R6: control registers only move on a write strobe
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(regs_q[CTRL_REG]) && $stable(regs_q[ENA_REG])))
        else $error("control register changed without write");

endmodule

// File: rtl/smbr_xfer.sv
module smbr_xfer
    import smbr_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'b1101110,
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS),
    localparam logic [7:0] CNT_BYTE = 8'(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            scl_rise_i,
    input  logic            scl_fall_i,
    input  logic            lock_i,
    input  logic [7:0]      rd_data_i,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [7:0]      wr_data_o,
    output logic [IDXW-1:0] rd_idx_o,
    output logic            sda_low_o
);

    typedef struct packed {
        phase_e          phase;
        kind_e           kind;
        logic [3:0]      bitcnt;
        logic [7:0]      sh;
        logic [IDXW-1:0] idx;
        logic [7:0]      rem;
        logic            ack;
        logic            mack;
        logic            rdmode;
    } xfer_t;

    xfer_t st_d, st_q;
    logic  wr_now;
    logic  ok;

    always_comb begin
        st_d   = st_q;
        wr_now = 1'b0;
        ok     = 1'b0;
        if (start_i) begin
            st_d.phase  = PH_RX;
            st_d.kind   = K_ADDR;
            st_d.bitcnt = '0;
            st_d.ack    = 1'b0;
            st_d.mack   = 1'b0;
        end else if (stop_i) begin
            st_d.phase = PH_IDLE;
            st_d.ack   = 1'b0;
            st_d.mack  = 1'b0;
        end else begin
            case (st_q.phase)
                PH_RX: begin
                    if (scl_rise_i && st_q.bitcnt != 4'd8) begin
                        st_d.sh     = {st_q.sh[6:0], sda_i};
                        st_d.bitcnt = st_q.bitcnt + 4'd1;
                    end else if (scl_fall_i && st_q.bitcnt == 4'd8) begin
                        case (st_q.kind)
                            K_ADDR: begin
                                ok          = (st_q.sh[7:1] == ADDR7) && !lock_i;
                                st_d.rdmode = st_q.sh[0];
                                st_d.kind   = K_INDEX;
                            end
                            K_INDEX: begin
                                ok        = !lock_i;
                                st_d.idx  = st_q.sh[IDXW-1:0];
                                st_d.kind = K_COUNT;
                            end
                            K_COUNT: begin
                                ok        = !lock_i && (st_q.sh != 8'd0);
                                st_d.rem  = st_q.sh;
                                st_d.kind = K_DATA;
                            end
                            default: begin
                                ok = !lock_i && (st_q.rem != 8'd0);
                                if (ok) begin
                                    wr_now   = 1'b1;
                                    st_d.idx = st_q.idx + 1'b1;
                                    st_d.rem = st_q.rem - 8'd1;
                                end
                            end
                        endcase
                        st_d.ack   = ok;
                        st_d.phase = PH_RXACK;
                    end
                end
                PH_RXACK: begin
                    if (scl_fall_i) begin
                        st_d.ack    = 1'b0;
                        st_d.bitcnt = '0;
                        if (!st_q.ack) begin
                            st_d.phase = PH_IGNORE;
                        end else if (st_q.rdmode && st_q.kind == K_INDEX) begin
                            st_d.phase = PH_TX;
                            st_d.sh    = CNT_BYTE;
                        end else begin
                            st_d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall_i) begin
                        st_d.sh     = {st_q.sh[6:0], 1'b0};
                        st_d.bitcnt = st_q.bitcnt + 4'd1;
                        if (st_q.bitcnt == 4'd7) begin
                            st_d.phase = PH_TXACK;
                            st_d.mack  = 1'b0;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise_i) begin
                        st_d.mack = !sda_i && !lock_i;
                    end else if (scl_fall_i) begin
                        if (st_q.mack) begin
                            st_d.phase  = PH_TX;
                            st_d.sh     = rd_data_i;
                            st_d.idx    = st_q.idx + 1'b1;
                            st_d.bitcnt = '0;
                        end else begin
                            st_d.phase = PH_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.kind   <= K_ADDR;
            st_q.bitcnt <= '0;
            st_q.sh     <= '0;
            st_q.idx    <= '0;
            st_q.rem    <= '0;
            st_q.ack    <= 1'b0;
            st_q.mack   <= 1'b0;
            st_q.rdmode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = wr_now;
    assign wr_idx_o  = st_q.idx;
    assign wr_data_o = st_q.sh;
    assign rd_idx_o  = st_q.idx;
    assign sda_low_o = ((st_q.phase == PH_TX) && !st_q.sh[7]) ||
                       ((st_q.phase == PH_RXACK) && st_q.ack);

    // R2: the data drive never moves while the clock line stays high
    a_r2_steady_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_low_o))
        else $error("SDA drive changed with SCL high");

    // R9: a STOP returns the slave to idle with the line released
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sda_low_o && st_q.phase == PH_IDLE))
        else $error("STOP did not release the slave");

    // R1: an address ACK is only given for the device address
    a_r1_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RXACK && st_q.kind == K_INDEX && st_q.ack) |->
            (st_q.sh[7:1] == ADDR7))
        else $error("address ACK for a foreign address");

endmodule

// File: rtl/smbus_ctl_regs.sv
module smbus_ctl_regs
    import smbr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101110,
    parameter int NREGS   = 8,
    parameter int NUM_OUT = 4,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_down,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull_low,
    output logic               pll_sel,
    output logic               bw_low,
    output logic               pd_mode,
    output logic [NUM_OUT-1:0] out_en
);

    logic            scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx, rd_idx;
    logic [7:0]      wr_data, rd_data, ctrl_r, ena_r;

    smbr_linesync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_in),
        .sda_i      (sda_in),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .start_o    (start_ev),
        .stop_o     (stop_ev),
        .scl_rise_o (rise_ev),
        .scl_fall_o (fall_ev)
    );

    smbr_xfer #(.ADDR7(DEV_ADDR), .NREGS(NREGS)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_s),
        .sda_i      (sda_s),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .scl_rise_i (rise_ev),
        .scl_fall_i (fall_ev),
        .lock_i     (pwr_down),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .rd_idx_o   (rd_idx),
        .sda_low_o  (sda_pull_low)
    );

    smbr_regfile #(.NREGS(NREGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ctrl_o  (ctrl_r),
        .ena_o   (ena_r)
    );

    assign pll_sel = ctrl_r[PLL_BIT];
    assign bw_low  = ctrl_r[BW_BIT];
    assign pd_mode = ctrl_r[PD_BIT];

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_ena
        assign out_en[n] = ena_r[ena_bit(n)];
    end

    // R8: with power-down held, the control outputs stay frozen
    a_r8_locked_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && $past(pwr_down)) |->
            $stable({pll_sel, bw_low, pd_mode, out_en}))
        else $error("control output moved during power-down");

endmodule

// File: tb/smbus_ctl_regs_test.sv
module smbus_ctl_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int H = 40;
    localparam logic [7:0] AW = 8'hDC;   // 1101110 + write
    localparam logic [7:0] AR = 8'hDD;   // 1101110 + read

    logic clk = 0, rst_n = 0, pwr_down = 0;
    logic scl_m = 1, sda_m = 1;
    logic sda_pull_low, pll_sel, bw_low, pd_mode;
    logic [3:0] out_en;
    wire  sda_bus = sda_m & ~sda_pull_low;

    int checks = 0, fails = 0, r2_viol = 0;
    bit done = 0;
    logic [7:0] rb [16];

    smbus_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .scl_in(scl_m), .sda_in(sda_bus), .sda_pull_low(sda_pull_low),
        .pll_sel(pll_sel), .bw_low(bw_low), .pd_mode(pd_mode), .out_en(out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R2 monitor: drive may only move while SCL is low
    logic prev_drive = 0, prev_scl = 1;
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_pull_low != prev_drive)) r2_viol++;
        prev_drive <= sda_pull_low;
        prev_scl   <= scl_m;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wc(H/2); scl_m = 1; wc(H); sda_m = 0; wc(H); scl_m = 0; wc(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 0; wc(H/2); scl_m = 1; wc(H); sda_m = 1; wc(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wc(H/2); scl_m = 1; wc(H); scl_m = 0; wc(H/2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1; wc(H/2); scl_m = 1; wc(H/2); b = sda_bus; wc(H/2); scl_m = 0; wc(H/2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~give_ack);
    endtask

    function automatic logic [7:0] ctrl_now();
        return {pd_mode, 4'b0, bw_low, pll_sel, 1'b0};
    endfunction

    // Read n registers from offset; rb[0] holds the count byte.
    task automatic read_regs(input logic [7:0] off, input int n, output logic aok);
        logic a1, a2, a3;
        bus_start(); send_byte(AW, a1); send_byte(off, a2);
        bus_start(); send_byte(AR, a3);
        aok = a1 & a2 & a3;
        if (aok) begin
            recv_byte(1'b1, rb[0]);
            for (int i = 1; i <= n; i++) recv_byte(i != n, rb[i]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        logic ok;
        chk("R6 reset ctrl", ctrl_now(), 8'h06);
        chk("R6 reset out_en", {4'b0, out_en}, 8'h0F);
        read_regs(8'd0, 5, ok);
        chk("R5 read acks", {7'b0, ok}, 8'h01);
        chk("R5 count byte", rb[0], 8'h08);
        chk("R6 reg0 read", rb[1], 8'h06);
        chk("R6 reg1 read", rb[2], 8'h66);
        chk("R7 reg2 read", rb[3], 8'h00);
        chk("R7 reg3 read", rb[4], 8'h00);
        chk("R6 id read", rb[5], 8'h20);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start(); send_byte(8'hA0, a);
        chk("R1 foreign addr nack", {7'b0, a}, 8'h00);
        send_byte(8'h00, a);
        chk("R1 ignored after nack", {7'b0, a}, 8'h00);
        bus_stop();
        chk("R1 ctrl unchanged", ctrl_now(), 8'h06);
    endtask

    task automatic t_write_basic();
        logic a0, a1, a2, a3, a4, ok;
        bus_start(); send_byte(AW, a0); send_byte(8'd0, a1); send_byte(8'd2, a2);
        send_byte(8'hFF, a3); send_byte(8'h00, a4); bus_stop();
        chk("R3 write acks", {3'b0, a0, a1, a2, a3, a4}, 8'h1F);
        chk("R3 ctrl after write", ctrl_now(), 8'h86);
        chk("R3 out_en after write", {4'b0, out_en}, 8'h00);
        read_regs(8'd0, 2, ok);
        chk("R7 reg0 masked", rb[1], 8'h86);
        chk("R3 reg1 readback", rb[2], 8'h00);
    endtask

    task automatic t_wrap_overcount();
        logic a0, a1, a2, a3, a4, a5;
        bus_start(); send_byte(AW, a0); send_byte(8'd7, a1); send_byte(8'd2, a2);
        send_byte(8'hAA, a3); send_byte(8'h02, a4); send_byte(8'h66, a5); bus_stop();
        chk("R10 wrap acks", {4'b0, a1, a2, a3, a4}, 8'h0F);
        chk("R3 extra byte nack", {7'b0, a5}, 8'h00);
        chk("R10 reg0 via wrap", ctrl_now(), 8'h02);
        chk("R3 extra byte discarded", {4'b0, out_en}, 8'h00);
    endtask

    task automatic t_zero_count();
        logic a0, a1, a2, a3;
        bus_start(); send_byte(AW, a0); send_byte(8'd1, a1); send_byte(8'd0, a2);
        send_byte(8'hFF, a3); bus_stop();
        chk("R4 zero count nack", {7'b0, a2}, 8'h00);
        chk("R4 following byte nack", {7'b0, a3}, 8'h00);
        chk("R4 out_en unchanged", {4'b0, out_en}, 8'h00);
    endtask

    task automatic t_stop_mid();
        logic a0, a1, a2, a3, ok;
        bus_start(); send_byte(AW, a0); send_byte(8'd1, a1); send_byte(8'd3, a2);
        send_byte(8'h66, a3); bus_stop();
        chk("R9 out_en after early stop", {4'b0, out_en}, 8'h0F);
        chk("R9 line released", {7'b0, sda_pull_low}, 8'h00);
        read_regs(8'd1, 2, ok);
        chk("R9 fresh transfer ok", {7'b0, ok}, 8'h01);
        chk("R9 reg1 kept", rb[1], 8'h66);
        chk("R7 reg2 still zero", rb[2], 8'h00);
    endtask

    task automatic t_id_write();
        logic a0, a1, a2, a3, ok;
        bus_start(); send_byte(AW, a0); send_byte(8'd4, a1); send_byte(8'd1, a2);
        send_byte(8'h00, a3); bus_stop();
        chk("R7 id write acked", {7'b0, a3}, 8'h01);
        read_regs(8'd4, 1, ok);
        chk("R7 id unchanged", rb[1], 8'h20);
    endtask

    task automatic t_lock();
        logic a;
        pwr_down = 1; wc(4);
        bus_start(); send_byte(AW, a); bus_stop();
        chk("R8 write addr nack", {7'b0, a}, 8'h00);
        bus_start(); send_byte(AR, a); bus_stop();
        chk("R8 read addr nack", {7'b0, a}, 8'h00);
        chk("R8 ctrl frozen", ctrl_now(), 8'h02);
        chk("R8 out_en frozen", {4'b0, out_en}, 8'h0F);
        pwr_down = 0; wc(4);
    endtask

    task automatic t_lock_collision();
        logic a0, a1, a2, a3, ok;
        bus_start(); send_byte(AW, a0); send_byte(8'd0, a1); send_byte(8'd1, a2);
        for (int i = 7; i >= 4; i--) put_bit(8'h86 >> i);
        pwr_down = 1;
        for (int i = 3; i >= 0; i--) put_bit(8'h86 >> i);
        get_bit(a3);
        bus_stop();
        chk("R8 setup acks", {5'b0, a0, a1, a2}, 8'h07);
        chk("R8 data nack under lock", {7'b0, ~a3}, 8'h00);
        chk("R8 ctrl kept under lock", ctrl_now(), 8'h02);
        pwr_down = 0; wc(4);
        read_regs(8'd0, 1, ok);
        chk("R8 nothing stored", rb[1], 8'h02);
    endtask

    task automatic t_read_wrap();
        logic ok;
        read_regs(8'd6, 4, ok);
        chk("R5 read wrap acks", {7'b0, ok}, 8'h01);
        chk("R10 read reg6", rb[1], 8'h00);
        chk("R10 read reg7", rb[2], 8'h00);
        chk("R10 read wraps reg0", rb[3], 8'h02);
        chk("R10 read wraps reg1", rb[4], 8'h66);
    endtask

    initial begin
        wc(5); rst_n = 1; wc(10);
        t_reset();
        t_bad_addr();
        t_write_basic();
        t_wrap_overcount();
        t_zero_count();
        t_stop_mid();
        t_id_write();
        t_lock();
        t_lock_collision();
        t_read_wrap();
        chk("R2 drive steady while SCL high", r2_viol[7:0], 8'h00);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule